// File: doc/BRIEF.md
# Split-Size Data Translation Lookaside Buffer

This block caches virtual-to-physical page translations for data accesses. A 48-bit virtual address presented on the lookup port is searched in the same cycle in three places: a set-associative array of 4KB translations and two small fully associative arrays, one for 2MB superpages and one for 1GB superpages. When any of them matches, the block returns the physical address and the stored permission bits. The physical address is formed from the matching entry's frame number and the untranslated page offset, and the offset width follows the size of the page that matched.

When nothing matches, the block reports a miss and raises a walk request. The page walker, which is outside this block, later writes its result through the fill port, and the fill port says which size of page the translation covers. Replacement is round-robin: per set in the 4KB array, and per array for each superpage size. A flush command invalidates every translation at the next clock edge.

Top module: `dtlb_split`

## Requirements
- R1: After reset every entry is invalid, so any lookup reports a miss and raises `walk_req`.
- R2: A 4KB fill (`fill_size` = 2'b00) makes a later lookup of the same page hit with `paddr` = {`fill_ppn`, `lk_vaddr[11:0]`} and `perm` equal to the filled `fill_perm`. The `perm` bits are dirty [0], privilege [2:1] and cacheable [3].
- R3: The 4KB array selects its set with `lk_vaddr[15:12]` and compares `lk_vaddr[47:16]` as the tag, so a page in the same set with a different tag misses.
- R4: Each 4KB set holds 4 ways replaced round-robin: the fifth fill into one set evicts that set's first translation, keeps the other three, and leaves other sets untouched.
- R5: A 2MB fill (`fill_size` = 2'b01) matches `lk_vaddr[47:21]` and gives `paddr` = {`fill_ppn[27:9]`, `lk_vaddr[20:0]`}.
- R6: A 1GB fill (`fill_size` = 2'b10) matches `lk_vaddr[47:30]` and gives `paddr` = {`fill_ppn[27:18]`, `lk_vaddr[29:0]`}.
- R7: When more than one size matches, the smaller page wins: 4KB over 2MB over 1GB, for both `paddr` and `perm`.
- R8: Each superpage array holds 4 translations replaced round-robin; the fifth fill of one size evicts that size's oldest translation only.
- R9: A lookup that matches nothing raises `walk_req` in the same cycle; `walk_req` never rises without a lookup.
- R10: A flush invalidates all translations of all sizes at the next edge; a fill in the same cycle as a flush is discarded.
- R11: `hit` and `miss` are both low when `lk_valid` is low, and exactly one of them is high when it is high.
- R12: A fill with `fill_size` = 2'b11 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 48 | Lookup virtual address |
| fill_valid | input | 1 | Fill request from the walker |
| fill_size | input | 2 | Page size of the fill: 00 4KB, 01 2MB, 10 1GB, 11 none |
| fill_vpn | input | 36 | Virtual page number (vaddr[47:12]) of the fill |
| fill_ppn | input | 28 | Physical page number (paddr[39:12]) of the fill |
| fill_perm | input | 4 | Dirty, privilege and cacheable bits of the fill |
| flush | input | 1 | Invalidate all translations |
| hit | output | 1 | Lookup matched a translation |
| miss | output | 1 | Lookup matched nothing |
| walk_req | output | 1 | Request to the page walker |
| paddr | output | 40 | Translated physical address |
| perm | output | 4 | Permission bits of the matching translation |

## Verification
Lookups are tried at addresses whose offset bits are all distinct, so a wrong offset width per page size shows in `paddr`. Addresses that share a set index but differ in tag separate indexing from tag compare, and a 4KB page placed inside a 2MB page, and a 2MB page inside a 1GB page, tell apart the order in which sizes win. Five fills into one set and five fills of one superpage size show which entry the round-robin pointer evicts, while lookups to neighbours show nothing else is disturbed; a flush issued together with a fill shows which of the two takes effect.

// File: rtl/dtlb_pkg.sv
package dtlb_pkg;
  localparam int VA_W   = 48;
  localparam int PA_W   = 40;
  localparam int OFF_4K = 12;
  localparam int OFF_2M = 21;
  localparam int OFF_1G = 30;
  localparam int VPN_W  = VA_W - OFF_4K;
  localparam int PPN_W  = PA_W - OFF_4K;

  typedef enum logic [1:0] {
    PG_4K   = 2'b00,
    PG_2M   = 2'b01,
    PG_1G   = 2'b10,
    PG_NONE = 2'b11
  } pg_size_e;

  // Join a 4KB-granular page number with the untranslated offset of a page size
  function automatic logic [PA_W-1:0] join_paddr(input pg_size_e sz,
                                                 input logic [PPN_W-1:0] ppn,
                                                 input logic [VA_W-1:0] va);
    logic [PA_W-1:0] pa;
    case (sz)
      PG_2M:   pa = {ppn[PPN_W-1:OFF_2M-OFF_4K], va[OFF_2M-1:0]};
      PG_1G:   pa = {ppn[PPN_W-1:OFF_1G-OFF_4K], va[OFF_1G-1:0]};
      default: pa = {ppn, va[OFF_4K-1:0]};
    endcase
    return pa;
  endfunction
endpackage

// File: rtl/tlb_set_array.sv
module tlb_set_array #(
  parameter int VPN_W  = 36,
  parameter int FR_W   = 28,
  parameter int SETS   = 16,
  parameter int WAYS   = 4,
  parameter int PERM_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [FR_W-1:0]   wr_frame,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              hit,
  output logic [FR_W-1:0]   frame,
  output logic [PERM_W-1:0] perm
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);

  logic              vld   [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q [SETS][WAYS];
  logic [FR_W-1:0]   fr_q  [SETS][WAYS];
  logic [PERM_W-1:0] pm_q  [SETS][WAYS];
  logic [WAY_W-1:0]  rr_q  [SETS];

  logic [IDX_W-1:0] lk_idx, wr_idx;
  logic [TAG_W-1:0] lk_tag, wr_tag;
  assign lk_idx = lk_vpn[IDX_W-1:0];
  assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
  assign wr_idx = wr_vpn[IDX_W-1:0];
  assign wr_tag = wr_vpn[VPN_W-1:IDX_W];

  always_comb begin
    hit   = 1'b0;
    frame = '0;
    perm  = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (vld[lk_idx][w] && tag_q[lk_idx][w] == lk_tag) begin
        hit   = 1'b1;
        frame = fr_q[lk_idx][w];
        perm  = pm_q[lk_idx][w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int s = 0; s < SETS; s++) begin
        for (int w = 0; w < WAYS; w++) vld[s][w] <= 1'b0;
        if (!rst_n) rr_q[s] <= '0;
      end
    end else if (wr_en) begin
      vld[wr_idx][rr_q[wr_idx]] <= 1'b1;
      rr_q[wr_idx]              <= rr_q[wr_idx] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush && wr_en) begin
      tag_q[wr_idx][rr_q[wr_idx]] <= wr_tag;
      fr_q[wr_idx][rr_q[wr_idx]]  <= wr_frame;
      pm_q[wr_idx][rr_q[wr_idx]]  <= wr_perm;
    end
  end
endmodule

// File: rtl/tlb_super_array.sv
module tlb_super_array #(
  parameter int TAG_W   = 27,
  parameter int FR_W    = 19,
  parameter int ENTRIES = 4,
  parameter int PERM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [FR_W-1:0]   wr_frame,
  input  logic [PERM_W-1:0] wr_perm,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              hit,
  output logic [FR_W-1:0]   frame,
  output logic [PERM_W-1:0] perm
);
  localparam int PTR_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [FR_W-1:0]    fr_q  [ENTRIES];
  logic [PERM_W-1:0]  pm_q  [ENTRIES];
  logic [PTR_W-1:0]   rr_q;
  logic [ENTRIES-1:0] match;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match[e] = vld[e] && (tag_q[e] == lk_tag);
  end

  always_comb begin
    hit   = |match;
    frame = '0;
    perm  = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (match[e]) begin
        frame = fr_q[e];
        perm  = pm_q[e];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      rr_q <= '0;
    end else if (flush) begin
      vld <= '0;
    end else if (wr_en) begin
      vld[rr_q] <= 1'b1;
      rr_q      <= rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush && wr_en) begin
      tag_q[rr_q] <= wr_tag;
      fr_q[rr_q]  <= wr_frame;
      pm_q[rr_q]  <= wr_perm;
    end
  end
endmodule

// File: rtl/dtlb_split.sv
module dtlb_split
  import dtlb_pkg::*;
#(
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int SP_ENTRIES = 4,
  parameter int PERM_W     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VA_W-1:0]   lk_vaddr,
  input  logic              fill_valid,
  input  logic [1:0]        fill_size,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              flush,
  output logic              hit,
  output logic              miss,
  output logic              walk_req,
  output logic [PA_W-1:0]   paddr,
  output logic [PERM_W-1:0] perm
);
  localparam int SH_2M  = OFF_2M - OFF_4K;
  localparam int SH_1G  = OFF_1G - OFF_4K;
  localparam int TAG_2M = VA_W - OFF_2M;
  localparam int TAG_1G = VA_W - OFF_1G;
  localparam int FR_2M  = PA_W - OFF_2M;
  localparam int FR_1G  = PA_W - OFF_1G;

  pg_size_e fsz;
  assign fsz = pg_size_e'(fill_size);

  logic wr_4k, wr_2m, wr_1g;
  assign wr_4k = fill_valid && fsz == PG_4K;
  assign wr_2m = fill_valid && fsz == PG_2M;
  assign wr_1g = fill_valid && fsz == PG_1G;

  logic              hit_4k, hit_2m, hit_1g;
  logic [PPN_W-1:0]  fr_4k;
  logic [FR_2M-1:0]  fr_2m;
  logic [FR_1G-1:0]  fr_1g;
  logic [PERM_W-1:0] pm_4k, pm_2m, pm_1g;

  tlb_set_array #(
    .VPN_W(VPN_W), .FR_W(PPN_W), .SETS(SETS), .WAYS(WAYS), .PERM_W(PERM_W)
  ) u_arr_4k (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr_4k), .wr_vpn(fill_vpn), .wr_frame(fill_ppn), .wr_perm(fill_perm),
    .lk_vpn(lk_vaddr[VA_W-1:OFF_4K]),
    .hit(hit_4k), .frame(fr_4k), .perm(pm_4k)
  );

  tlb_super_array #(
    .TAG_W(TAG_2M), .FR_W(FR_2M), .ENTRIES(SP_ENTRIES), .PERM_W(PERM_W)
  ) u_arr_2m (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr_2m), .wr_tag(fill_vpn[VPN_W-1:SH_2M]),
    .wr_frame(fill_ppn[PPN_W-1:SH_2M]), .wr_perm(fill_perm),
    .lk_tag(lk_vaddr[VA_W-1:OFF_2M]),
    .hit(hit_2m), .frame(fr_2m), .perm(pm_2m)
  );

  tlb_super_array #(
    .TAG_W(TAG_1G), .FR_W(FR_1G), .ENTRIES(SP_ENTRIES), .PERM_W(PERM_W)
  ) u_arr_1g (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .wr_en(wr_1g), .wr_tag(fill_vpn[VPN_W-1:SH_1G]),
    .wr_frame(fill_ppn[PPN_W-1:SH_1G]), .wr_perm(fill_perm),
    .lk_tag(lk_vaddr[VA_W-1:OFF_1G]),
    .hit(hit_1g), .frame(fr_1g), .perm(pm_1g)
  );

  // Smallest matching page size wins
  pg_size_e         win_sz;
  logic [PPN_W-1:0] win_ppn;
  logic             any_hit;

  always_comb begin
    win_sz  = PG_NONE;
    win_ppn = '0;
    perm    = '0;
    if (hit_4k) begin
      win_sz  = PG_4K;
      win_ppn = fr_4k;
      perm    = pm_4k;
    end else if (hit_2m) begin
      win_sz  = PG_2M;
      win_ppn = {fr_2m, {SH_2M{1'b0}}};
      perm    = pm_2m;
    end else if (hit_1g) begin
      win_sz  = PG_1G;
      win_ppn = {fr_1g, {SH_1G{1'b0}}};
      perm    = pm_1g;
    end
  end

  assign any_hit  = win_sz != PG_NONE;
  assign hit      = lk_valid && any_hit;
  assign miss     = lk_valid && !any_hit;
  assign walk_req = miss;
  assign paddr    = join_paddr(win_sz, win_ppn, lk_vaddr);
endmodule

// File: rtl/dtlb_split_chk.sv
module dtlb_split_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        flush,
  input logic        fill_valid,
  input logic [1:0]  fill_size,
  input logic [35:0] fill_vpn,
  input logic        lk_valid,
  input logic [47:0] lk_vaddr,
  input logic        hit,
  input logic        miss,
  input logic        walk_req,
  input logic [39:0] paddr,
  input logic        hit_4k,
  input logic        hit_2m,
  input logic        hit_1g
);
  AST_HIT_MISS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |-> $countones({hit, miss}) == 1); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |-> !hit && !miss); // R11
  AST_WALK_ONLY_ON_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req |-> lk_valid && !hit); // R9
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !hit); // R10
  AST_FILL_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush && fill_size != 2'b11) |=>
      (!(lk_valid && lk_vaddr[47:12] == $past(fill_vpn)) || hit)); // R2
  AST_OFFSET_4K: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> paddr[11:0] == lk_vaddr[11:0]); // R2
  AST_OFFSET_2M: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && hit_2m && !hit_4k) |-> paddr[20:0] == lk_vaddr[20:0]); // R5
  AST_OFFSET_1G: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && hit_1g && !hit_2m && !hit_4k) |-> paddr[29:0] == lk_vaddr[29:0]); // R6
endmodule

bind dtlb_split dtlb_split_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fill_valid(fill_valid),
  .fill_size(fill_size), .fill_vpn(fill_vpn), .lk_valid(lk_valid),
  .lk_vaddr(lk_vaddr), .hit(hit), .miss(miss), .walk_req(walk_req),
  .paddr(paddr), .hit_4k(hit_4k), .hit_2m(hit_2m), .hit_1g(hit_1g)
);

// File: tb/tb_dtlb_split.sv
module tb_dtlb_split;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0;
  logic [47:0] lk_vaddr = '0;
  logic        fill_valid = 1'b0;
  logic [1:0]  fill_size = 2'b00;
  logic [35:0] fill_vpn = '0;
  logic [27:0] fill_ppn = '0;
  logic [3:0]  fill_perm = '0;
  logic        flush = 1'b0;
  logic        hit, miss, walk_req;
  logic [39:0] paddr;
  logic [3:0]  perm;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dtlb_split dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .fill_valid(fill_valid), .fill_size(fill_size), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_perm(fill_perm), .flush(flush),
    .hit(hit), .miss(miss), .walk_req(walk_req), .paddr(paddr), .perm(perm)
  );

  typedef struct packed {
    logic        is_lk;
    logic [1:0]  sz;
    logic [47:0] va;
    logic [39:0] pa;
    logic [3:0]  pm;
    logic        exp_hit;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'b00, 48'h0000_1234_5000, 40'h00_ABCD_E000, 4'hB, 1'b0, 8'd2},
    '{1'b1, 2'b00, 48'h0000_1234_5ABC, 40'h00_ABCD_EABC, 4'hB, 1'b1, 8'd2},  // R2
    '{1'b1, 2'b00, 48'h0000_1235_5ABC, 40'h0,            4'h0, 1'b0, 8'd3},  // R3
    '{1'b0, 2'b01, 48'h0000_4060_0000, 40'h00_8000_0000, 4'h5, 1'b0, 8'd5},
    '{1'b1, 2'b00, 48'h0000_407F_FFFF, 40'h00_801F_FFFF, 4'h5, 1'b1, 8'd5},  // R5
    '{1'b0, 2'b10, 48'h0001_C000_0000, 40'h40_0000_0000, 4'h9, 1'b0, 8'd6},
    '{1'b1, 2'b00, 48'h0001_F123_4567, 40'h40_3123_4567, 4'h9, 1'b1, 8'd6},  // R6
    '{1'b0, 2'b00, 48'h0000_4061_3000, 40'h00_0003_3000, 4'h1, 1'b0, 8'd7},
    '{1'b1, 2'b00, 48'h0000_4061_3010, 40'h00_0003_3010, 4'h1, 1'b1, 8'd7},  // R7
    '{1'b1, 2'b00, 48'h0000_4061_4010, 40'h00_8001_4010, 4'h5, 1'b1, 8'd7},  // R7
    '{1'b0, 2'b01, 48'h0001_C020_0000, 40'h00_C000_0000, 4'h3, 1'b0, 8'd7},
    '{1'b1, 2'b00, 48'h0001_C021_0000, 40'h00_C001_0000, 4'h3, 1'b1, 8'd7},  // R7
    '{1'b1, 2'b00, 48'h7FFF_0000_0000, 40'h0,            4'h0, 1'b0, 8'd9}   // R9
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_fill(input logic [1:0] sz, input logic [47:0] va,
                         input logic [39:0] pa, input logic [3:0] pm,
                         input logic with_flush);
    @(negedge clk);
    lk_valid   = 1'b0;
    fill_valid = 1'b1;
    fill_size  = sz;
    fill_vpn   = va[47:12];
    fill_ppn   = pa[39:12];
    fill_perm  = pm;
    flush      = with_flush;
    @(negedge clk);
    fill_valid = 1'b0;
    flush      = 1'b0;
  endtask

  // Lookup and compare; expected physical address only checked on a hit
  task automatic do_look(input logic [47:0] va, input logic exp_hit,
                         input logic [39:0] exp_pa, input logic [3:0] exp_pm,
                         input string req);
    @(negedge clk);
    lk_valid = 1'b1;
    lk_vaddr = va;
    #1;
    check(hit == exp_hit && miss == !exp_hit && walk_req == !exp_hit, req,
          {61'd0, hit, miss, walk_req}, {61'd0, exp_hit, !exp_hit, !exp_hit});
    if (exp_hit) begin
      check(paddr == exp_pa, req, 64'(paddr), 64'(exp_pa));
      check(perm == exp_pm, req, 64'(perm), 64'(exp_pm));
    end
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty after reset
    do_look(48'h0000_1234_5000, 1'b0, 40'h0, 4'h0, "R1");
    // R11: idle port stays quiet
    @(negedge clk);
    lk_valid = 1'b0;
    #1;
    check(!hit && !miss && !walk_req, "R11", {61'd0, hit, miss, walk_req}, 64'd0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].is_lk)
        do_look(VECS[i].va, VECS[i].exp_hit, VECS[i].pa, VECS[i].pm,
                $sformatf("R%0d", VECS[i].req));
      else
        do_fill(VECS[i].sz, VECS[i].va, VECS[i].pa, VECS[i].pm, 1'b0);
    end

    // R4: five fills into set 3, first one evicted
    for (int t = 1; t <= 5; t++)
      do_fill(2'b00, (48'(t) << 20) | 48'h3000, 40'h10_0000_0000 | (40'(t) << 12),
              4'(t), 1'b0);
    do_look((48'd1 << 20) | 48'h3044, 1'b0, 40'h0, 4'h0, "R4");
    for (int t = 2; t <= 5; t++)
      do_look((48'(t) << 20) | 48'h3044, 1'b1,
              40'h10_0000_0000 | (40'(t) << 12) | 40'h044, 4'(t), "R4");
    do_look(48'h0000_1234_5ABC, 1'b1, 40'h00_ABCD_EABC, 4'hB, "R4");

    // R8: three more 2MB fills wrap the pointer onto the oldest 2MB entry
    for (int k = 0; k < 3; k++)
      do_fill(2'b01, 48'h0002_0000_0000 + (48'(k) << 21),
              40'h20_0000_0000 + (40'(k) << 21), 4'hE, 1'b0);
    do_look(48'h0000_407F_FFFF, 1'b0, 40'h0, 4'h0, "R8");
    do_look(48'h0001_C021_0000, 1'b1, 40'h00_C001_0000, 4'h3, "R8");
    do_look(48'h0002_0041_2345, 1'b1, 40'h20_0041_2345, 4'hE, "R8");

    // R12: size code 11 writes nothing
    do_fill(2'b11, 48'h0003_0000_0000, 40'h30_0000_0000, 4'h7, 1'b0);
    do_look(48'h0003_0000_0000, 1'b0, 40'h0, 4'h0, "R12");

    // R10: flush beats a fill in the same cycle
    do_fill(2'b00, 48'h0005_0000_0000, 40'h50_0000_0000, 4'h2, 1'b1);
    do_look(48'h0000_1234_5ABC, 1'b0, 40'h0, 4'h0, "R10");
    do_look(48'h0001_F123_4567, 1'b0, 40'h0, 4'h0, "R10");
    do_look(48'h0001_C021_0000, 1'b0, 40'h0, 4'h0, "R10");
    do_look(48'h0005_0000_0000, 1'b0, 40'h0, 4'h0, "R10");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule